// File: doc/BRIEF.md
# Graphics Command Packet Decoder

This block sits at the front of a graphics engine. It takes a stream of 32-bit command words and groups them into packets. The top byte of the first word of each packet is the opcode, and the low 24 bits are its parameter. Most opcodes form a packet of one word. A setting opcode updates the drawing-state registers that the later pipeline stages read: draw mode, texture window, clip rectangle, drawing offset and mask control. A polygon opcode starts a multi-word packet. The block works out the packet length from the opcode's flag bits. It counts the words in flight until that length is reached, then issues a one-cycle descriptor to the rasteriser.

Words arrive on two paths. One is a direct valid/ready write port. The other is a DMA forwarding port, whose words count as commands only when the DMA-direction input selects the command port; in any other direction the word is thrown away and an error pulse is raised. A DMA word has priority over a direct word in the same cycle. Opcodes at 0x40 or above that this block does not decode are consumed as single words and flagged.

Top module: `gfx_cmd_decoder`

## Requirements
- R1: After reset, all drawing-state outputs are zero, the pulse outputs `poly_valid`, `unimpl_cmd` and `dma_drop` are low, and `cmd_ready` is high while `dma_valid` is low.
- R2: Opcode 0x00, and any other opcode below 0x20, is a single-word packet. It leaves every drawing-state output unchanged and raises no pulse.
- R3: Opcode 0xE1 loads `draw_mode` from parameter bits 10:0, `tex_disable` from bit 11, `tex_flip_x` from bit 12 and `tex_flip_y` from bit 13.
- R4: Opcode 0xE2 loads four 5-bit fields, in units of 8 pixels: `win_mask_x` from parameter bits 4:0, `win_mask_y` from bits 9:5, `win_off_x` from bits 14:10 and `win_off_y` from bits 19:15.
- R5: Opcode 0xE3 loads the top-left clip corner and opcode 0xE4 loads the bottom-right clip corner. In both cases X comes from parameter bits 9:0 and Y from bits 18:10.
- R6: Opcode 0xE5 loads `ofs_x` from parameter bits 10:0 and `ofs_y` from bits 21:11. Each value is an 11-bit two's complement number, sign-extended to OFS_W bits with bit 10 as the sign.
- R7: Opcode 0xE6 loads `mask_force` from parameter bit 0 and `mask_test` from bit 1.
- R8: Opcodes 0x20 to 0x3F are polygons, and their flag bits are: bit 1 semi-transparent, bit 2 textured, bit 3 four vertices (otherwise three), bit 4 shaded. The packet length is (1 + textured + shaded) × vertices, plus one when not shaded. In the cycle after the last word is accepted, `poly_valid` is high for exactly one cycle with `poly_verts`, `poly_semi`, `poly_tex`, `poly_shade` and `poly_words` taken from the header.
- R9: Words after the first word of a polygon packet never change the drawing state, whatever their top byte holds.
- R10: A DMA word whose `dma_dir` differs from 2 (the code for "to command port") is not accepted. `dma_drop` pulses in the next cycle, and the packet state and drawing state stay unchanged. With `dma_dir` equal to 2, the word is accepted like a direct write.
- R11: An opcode at or above 0x40 other than 0xE1 to 0xE6 is consumed as a single word. It pulses `unimpl_cmd` in the next cycle and leaves the drawing state unchanged.
- R12: While `dma_valid` is high, `cmd_ready` is low and direct words are not taken.
- R13: No more than BUF_DEPTH (12) words of one packet are ever held. The longest polygon, textured, shaded and four-vertex, completes at exactly 12 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Direct command word valid |
| cmd_data | input | 32 | Direct command word |
| cmd_ready | output | 1 | Direct word can be taken |
| dma_valid | input | 1 | DMA forwarded word valid |
| dma_data | input | 32 | DMA forwarded word |
| dma_dir | input | DIR_W (2) | Current DMA direction; 2 means to command port |
| draw_mode | output | 11 | Draw mode status bits |
| tex_disable | output | 1 | Texture disable |
| tex_flip_x | output | 1 | Texture X flip |
| tex_flip_y | output | 1 | Texture Y flip |
| win_mask_x | output | 5 | Texture window mask X (8-pixel units) |
| win_mask_y | output | 5 | Texture window mask Y (8-pixel units) |
| win_off_x | output | 5 | Texture window offset X (8-pixel units) |
| win_off_y | output | 5 | Texture window offset Y (8-pixel units) |
| clip_x0 | output | 10 | Clip rectangle left |
| clip_y0 | output | 9 | Clip rectangle top |
| clip_x1 | output | 10 | Clip rectangle right |
| clip_y1 | output | 9 | Clip rectangle bottom |
| ofs_x | output | OFS_W (16) | Signed drawing offset X |
| ofs_y | output | OFS_W (16) | Signed drawing offset Y |
| mask_force | output | 1 | Force mask bit on drawn pixels |
| mask_test | output | 1 | Skip pixels whose mask bit is set |
| poly_valid | output | 1 | One-cycle polygon descriptor strobe |
| poly_verts | output | 3 | Vertex count, 3 or 4 |
| poly_semi | output | 1 | Semi-transparent polygon |
| poly_tex | output | 1 | Textured polygon |
| poly_shade | output | 1 | Shaded polygon |
| poly_words | output | 4 | Length of the completed packet in words |
| unimpl_cmd | output | 1 | Undecoded high opcode was discarded |
| dma_drop | output | 1 | DMA word dropped because of the direction |

## Verification
The hardest case to reach is a rejected DMA word, or a payload word whose top byte looks like a setting opcode, arriving in the middle of a polygon packet. The count must resume without loss, and the state must not be written by the payload. The random stimulus fills polygon payloads with arbitrary words, some forced to carry 0xE1 to 0xE6 in the top byte. It also scatters DMA words with random directions between and inside packets. Directed cases add the 12-word polygon, negative offsets, and a direct write that collides with a rejected DMA word.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

   localparam logic [7:0] OP_NOP       = 8'h00;
   localparam logic [7:0] OP_DRAW_MODE = 8'hE1;
   localparam logic [7:0] OP_TEX_WIN   = 8'hE2;
   localparam logic [7:0] OP_CLIP_TL   = 8'hE3;
   localparam logic [7:0] OP_CLIP_BR   = 8'hE4;
   localparam logic [7:0] OP_OFFSET    = 8'hE5;
   localparam logic [7:0] OP_MASK      = 8'hE6;

   typedef struct packed {
      logic [2:0] verts;
      logic       semi;
      logic       tex;
      logic       shade;
      logic [3:0] words;
   } poly_desc_t;

   function automatic logic is_setting(input logic [7:0] op);
      return (op >= OP_DRAW_MODE) && (op <= OP_MASK);
   endfunction

endpackage

// File: rtl/gfx_poly_len.sv
module gfx_poly_len
   import gfx_cmd_pkg::*;
(
   input  logic [7:0] opcode,
   output logic       is_poly,
   output poly_desc_t desc
);
   logic [3:0] per_vert;

   always_comb begin
      is_poly    = (opcode[7:5] == 3'b001);
      per_vert   = 4'd1 + {3'd0, opcode[2]} + {3'd0, opcode[4]};
      desc.verts = opcode[3] ? 3'd4 : 3'd3;
      desc.semi  = opcode[1];
      desc.tex   = opcode[2];
      desc.shade = opcode[4];
      desc.words = (opcode[3] ? (per_vert << 2) : (per_vert + (per_vert << 1)))
                   + {3'd0, ~opcode[4]};
   end
endmodule

// File: rtl/gfx_pkt_assembler.sv
module gfx_pkt_assembler
   import gfx_cmd_pkg::*;
#(
   parameter int BUF_DEPTH = 12,
   localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [31:0]      word,
   output logic             done,
   output logic             done_poly,
   output logic [31:0]      head,
   output poly_desc_t       desc,
   output logic [CNT_W-1:0] fill
);
   logic [31:0]      head_q;
   logic [CNT_W-1:0] cnt_q;
   logic             is_poly;
   logic [CNT_W-1:0] need;

   if (BUF_DEPTH < 12) begin : g_depth_check
      $error("BUF_DEPTH must hold the longest polygon packet of 12 words");
   end

   assign head = (cnt_q == '0) ? word : head_q;

   gfx_poly_len u_len (
      .opcode  (head[31:24]),
      .is_poly (is_poly),
      .desc    (desc)
   );

   assign need      = is_poly ? CNT_W'(desc.words) : CNT_W'(1);
   assign done      = accept && ((cnt_q + CNT_W'(1)) == need);
   assign done_poly = done && is_poly;
   assign fill      = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         head_q <= '0;
      end else if (accept) begin
         if (cnt_q == '0) head_q <= word;
         cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
      end
   end

   p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(BUF_DEPTH));

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cnt_q == '0));
endmodule

// File: rtl/gfx_state_regs.sv
module gfx_state_regs
   import gfx_cmd_pkg::*;
#(
   parameter int OFS_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [31:0]      head,
   output logic [10:0]      draw_mode,
   output logic             tex_disable,
   output logic             tex_flip_x,
   output logic             tex_flip_y,
   output logic [4:0]       win_mask_x,
   output logic [4:0]       win_mask_y,
   output logic [4:0]       win_off_x,
   output logic [4:0]       win_off_y,
   output logic [9:0]       clip_x0,
   output logic [8:0]       clip_y0,
   output logic [9:0]       clip_x1,
   output logic [8:0]       clip_y1,
   output logic [OFS_W-1:0] ofs_x,
   output logic [OFS_W-1:0] ofs_y,
   output logic             mask_force,
   output logic             mask_test
);
   localparam int RAW_W = 11;

   logic [7:0]       op;
   logic [23:0]      prm;
   logic [OFS_W-1:0] ofs_ext [2];

   if (OFS_W < RAW_W) begin : g_width_check
      $error("OFS_W must be at least 11 bits");
   end

   assign op  = head[31:24];
   assign prm = head[23:0];

   for (genvar a = 0; a < 2; a++) begin : g_axis
      if (OFS_W > RAW_W) begin : g_ext
         assign ofs_ext[a] = {{(OFS_W-RAW_W){prm[a*RAW_W + RAW_W-1]}}, prm[a*RAW_W +: RAW_W]};
      end else begin : g_same
         assign ofs_ext[a] = prm[a*RAW_W +: RAW_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draw_mode   <= '0;
         tex_disable <= 1'b0;
         tex_flip_x  <= 1'b0;
         tex_flip_y  <= 1'b0;
         win_mask_x  <= '0;
         win_mask_y  <= '0;
         win_off_x   <= '0;
         win_off_y   <= '0;
         clip_x0     <= '0;
         clip_y0     <= '0;
         clip_x1     <= '0;
         clip_y1     <= '0;
         ofs_x       <= '0;
         ofs_y       <= '0;
         mask_force  <= 1'b0;
         mask_test   <= 1'b0;
      end else if (upd) begin
         case (op)
            OP_DRAW_MODE: begin
               draw_mode   <= prm[10:0];
               tex_disable <= prm[11];
               tex_flip_x  <= prm[12];
               tex_flip_y  <= prm[13];
            end
            OP_TEX_WIN: begin
               win_mask_x <= prm[4:0];
               win_mask_y <= prm[9:5];
               win_off_x  <= prm[14:10];
               win_off_y  <= prm[19:15];
            end
            OP_CLIP_TL: begin
               clip_x0 <= prm[9:0];
               clip_y0 <= prm[18:10];
            end
            OP_CLIP_BR: begin
               clip_x1 <= prm[9:0];
               clip_y1 <= prm[18:10];
            end
            OP_OFFSET: begin
               ofs_x <= ofs_ext[0];
               ofs_y <= ofs_ext[1];
            end
            OP_MASK: begin
               mask_force <= prm[0];
               mask_test  <= prm[1];
            end
            default: ;
         endcase
      end
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(draw_mode) && $stable(win_mask_x) && $stable(clip_x0)
                && $stable(ofs_x) && $stable(ofs_y) && $stable(mask_force)));
endmodule

// File: rtl/gfx_cmd_decoder.sv
module gfx_cmd_decoder
   import gfx_cmd_pkg::*;
#(
   parameter int BUF_DEPTH   = 12,
   parameter int OFS_W       = 16,
   parameter int DIR_W       = 2,
   parameter int DIR_TO_CMD  = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [31:0]      cmd_data,
   output logic             cmd_ready,
   input  logic             dma_valid,
   input  logic [31:0]      dma_data,
   input  logic [DIR_W-1:0] dma_dir,
   output logic [10:0]      draw_mode,
   output logic             tex_disable,
   output logic             tex_flip_x,
   output logic             tex_flip_y,
   output logic [4:0]       win_mask_x,
   output logic [4:0]       win_mask_y,
   output logic [4:0]       win_off_x,
   output logic [4:0]       win_off_y,
   output logic [9:0]       clip_x0,
   output logic [8:0]       clip_y0,
   output logic [9:0]       clip_x1,
   output logic [8:0]       clip_y1,
   output logic [OFS_W-1:0] ofs_x,
   output logic [OFS_W-1:0] ofs_y,
   output logic             mask_force,
   output logic             mask_test,
   output logic             poly_valid,
   output logic [2:0]       poly_verts,
   output logic             poly_semi,
   output logic             poly_tex,
   output logic             poly_shade,
   output logic [3:0]       poly_words,
   output logic             unimpl_cmd,
   output logic             dma_drop
);
   localparam int CNT_W = $clog2(BUF_DEPTH + 1);

   if (DIR_TO_CMD >= (1 << DIR_W)) begin : g_dir_check
      $error("DIR_TO_CMD does not fit in DIR_W bits");
   end

   logic             dir_ok;
   logic             accept;
   logic [31:0]      word;
   logic             done;
   logic             done_poly;
   logic [31:0]      head;
   poly_desc_t       desc;
   logic [CNT_W-1:0] fill;
   logic             upd;
   logic             undecoded;

   assign dir_ok    = (dma_dir == DIR_W'(DIR_TO_CMD));
   assign cmd_ready = !dma_valid;
   assign accept    = dma_valid ? dir_ok : cmd_valid;
   assign word      = dma_valid ? dma_data : cmd_data;

   gfx_pkt_assembler #(.BUF_DEPTH(BUF_DEPTH)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .word      (word),
      .done      (done),
      .done_poly (done_poly),
      .head      (head),
      .desc      (desc),
      .fill      (fill)
   );

   assign upd       = done && !done_poly;
   assign undecoded = (head[31:24] >= 8'h40) && !is_setting(head[31:24]);

   gfx_state_regs #(.OFS_W(OFS_W)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd         (upd),
      .head        (head),
      .draw_mode   (draw_mode),
      .tex_disable (tex_disable),
      .tex_flip_x  (tex_flip_x),
      .tex_flip_y  (tex_flip_y),
      .win_mask_x  (win_mask_x),
      .win_mask_y  (win_mask_y),
      .win_off_x   (win_off_x),
      .win_off_y   (win_off_y),
      .clip_x0     (clip_x0),
      .clip_y0     (clip_y0),
      .clip_x1     (clip_x1),
      .clip_y1     (clip_y1),
      .ofs_x       (ofs_x),
      .ofs_y       (ofs_y),
      .mask_force  (mask_force),
      .mask_test   (mask_test)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         poly_valid <= 1'b0;
         poly_verts <= '0;
         poly_semi  <= 1'b0;
         poly_tex   <= 1'b0;
         poly_shade <= 1'b0;
         poly_words <= '0;
         unimpl_cmd <= 1'b0;
         dma_drop   <= 1'b0;
      end else begin
         poly_valid <= done_poly;
         if (done_poly) begin
            poly_verts <= desc.verts;
            poly_semi  <= desc.semi;
            poly_tex   <= desc.tex;
            poly_shade <= desc.shade;
            poly_words <= desc.words;
         end
         unimpl_cmd <= upd && undecoded;
         dma_drop   <= dma_valid && !dir_ok;
      end
   end

   p_desc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      poly_valid |=> !poly_valid);

   p_drop_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_valid && !dir_ok) |=> ($stable(fill) && !poly_valid && !unimpl_cmd));

   p_unimpl_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl_cmd |-> !poly_valid);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!poly_valid && !unimpl_cmd && !dma_drop));
endmodule

// File: tb/gfx_cmd_decoder_tb.sv
module gfx_cmd_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_data = '0;
   logic        cmd_ready;
   logic        dma_valid = 1'b0;
   logic [31:0] dma_data = '0;
   logic [1:0]  dma_dir = 2'd0;
   logic [10:0] draw_mode;
   logic        tex_disable, tex_flip_x, tex_flip_y;
   logic [4:0]  win_mask_x, win_mask_y, win_off_x, win_off_y;
   logic [9:0]  clip_x0, clip_x1;
   logic [8:0]  clip_y0, clip_y1;
   logic [15:0] ofs_x, ofs_y;
   logic        mask_force, mask_test;
   logic        poly_valid;
   logic [2:0]  poly_verts;
   logic        poly_semi, poly_tex, poly_shade;
   logic [3:0]  poly_words;
   logic        unimpl_cmd, dma_drop;

   int total = 0;
   int bad   = 0;

   // expected model
   logic [10:0] e_mode;
   logic        e_tdis, e_fx, e_fy, e_mf, e_mt;
   logic [4:0]  e_wmx, e_wmy, e_wox, e_woy;
   logic [9:0]  e_x0, e_x1;
   logic [8:0]  e_y0, e_y1;
   logic [15:0] e_ox, e_oy;
   int          e_cnt;
   logic [31:0] e_head;
   logic        e_poly, e_unimpl, e_drop;
   logic [2:0]  e_verts;
   logic        e_semi, e_tex, e_shade;
   logic [3:0]  e_words;

   always #10 clk = ~clk;

   gfx_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
      .dma_valid(dma_valid), .dma_data(dma_data), .dma_dir(dma_dir),
      .draw_mode(draw_mode), .tex_disable(tex_disable),
      .tex_flip_x(tex_flip_x), .tex_flip_y(tex_flip_y),
      .win_mask_x(win_mask_x), .win_mask_y(win_mask_y),
      .win_off_x(win_off_x), .win_off_y(win_off_y),
      .clip_x0(clip_x0), .clip_y0(clip_y0), .clip_x1(clip_x1), .clip_y1(clip_y1),
      .ofs_x(ofs_x), .ofs_y(ofs_y), .mask_force(mask_force), .mask_test(mask_test),
      .poly_valid(poly_valid), .poly_verts(poly_verts), .poly_semi(poly_semi),
      .poly_tex(poly_tex), .poly_shade(poly_shade), .poly_words(poly_words),
      .unimpl_cmd(unimpl_cmd), .dma_drop(dma_drop)
   );

   function automatic int pkt_len(input logic [7:0] op);
      int per;
      if (op[7:5] != 3'b001) return 1;
      per = 1 + int'(op[2]) + int'(op[4]);
      return per * (op[3] ? 4 : 3) + (op[4] ? 0 : 1);
   endfunction

   function automatic logic [127:0] dut_state();
      return {draw_mode, tex_disable, tex_flip_x, tex_flip_y,
              win_mask_x, win_mask_y, win_off_x, win_off_y,
              clip_x0, clip_y0, clip_x1, clip_y1, ofs_x, ofs_y, mask_force, mask_test};
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      e_mode = '0; e_tdis = 0; e_fx = 0; e_fy = 0; e_mf = 0; e_mt = 0;
      e_wmx = '0; e_wmy = '0; e_wox = '0; e_woy = '0;
      e_x0 = '0; e_x1 = '0; e_y0 = '0; e_y1 = '0; e_ox = '0; e_oy = '0;
      e_cnt = 0; e_head = '0;
      e_verts = '0; e_semi = 0; e_tex = 0; e_shade = 0; e_words = '0;
   endtask

   task automatic model_word(input logic [31:0] w);
      logic [31:0] h;
      logic [23:0] p;
      int need;
      h = (e_cnt == 0) ? w : e_head;
      if (e_cnt == 0) e_head = w;
      need = pkt_len(h[31:24]);
      p = h[23:0];
      e_cnt++;
      if (e_cnt == need) begin
         e_cnt = 0;
         if (h[31:29] == 3'b001) begin
            e_poly = 1;
            e_verts = h[27] ? 3'd4 : 3'd3;
            e_semi = h[25]; e_tex = h[26]; e_shade = h[28];
            e_words = 4'(need);
         end else begin
            case (h[31:24])
               8'hE1: begin e_mode = p[10:0]; e_tdis = p[11]; e_fx = p[12]; e_fy = p[13]; end
               8'hE2: begin e_wmx = p[4:0]; e_wmy = p[9:5]; e_wox = p[14:10]; e_woy = p[19:15]; end
               8'hE3: begin e_x0 = p[9:0]; e_y0 = p[18:10]; end
               8'hE4: begin e_x1 = p[9:0]; e_y1 = p[18:10]; end
               8'hE5: begin e_ox = {{5{p[10]}}, p[10:0]}; e_oy = {{5{p[21]}}, p[21:11]}; end
               8'hE6: begin e_mf = p[0]; e_mt = p[1]; end
               default: if (h[31:24] >= 8'h40) e_unimpl = 1;
            endcase
         end
      end
   endtask

   task automatic check_all();
      chk("R8 poly_valid", 128'(poly_valid), 128'(e_poly));
      if (e_poly)
         chk("R8 descriptor", 128'({poly_verts, poly_semi, poly_tex, poly_shade, poly_words}),
             128'({e_verts, e_semi, e_tex, e_shade, e_words}));
      chk("R11 unimpl_cmd", 128'(unimpl_cmd), 128'(e_unimpl));
      chk("R10 dma_drop", 128'(dma_drop), 128'(e_drop));
      chk("R3 draw mode", 128'({draw_mode, tex_disable, tex_flip_x, tex_flip_y}),
          128'({e_mode, e_tdis, e_fx, e_fy}));
      chk("R4 texture window", 128'({win_mask_x, win_mask_y, win_off_x, win_off_y}),
          128'({e_wmx, e_wmy, e_wox, e_woy}));
      chk("R5 clip area", 128'({clip_x0, clip_y0, clip_x1, clip_y1}),
          128'({e_x0, e_y0, e_x1, e_y1}));
      chk("R6 offset", 128'({ofs_x, ofs_y}), 128'({e_ox, e_oy}));
      chk("R7 mask", 128'({mask_force, mask_test}), 128'({e_mf, e_mt}));
   endtask

   // via: 0 direct, 1 DMA; collide drives a direct word alongside the DMA word
   task automatic send(input logic [31:0] w, input bit via, input logic [1:0] dir,
                       input bit collide);
      @(negedge clk);
      e_poly = 0; e_unimpl = 0; e_drop = 0;
      if (via) begin
         dma_valid = 1; dma_data = w; dma_dir = dir;
         cmd_valid = collide; cmd_data = ~w;
         #1 chk("R12 cmd_ready low under DMA", 128'(cmd_ready), 128'(0));
         if (dir == 2'd2) model_word(w); else e_drop = 1;
      end else begin
         cmd_valid = 1; cmd_data = w; dma_valid = 0;
         model_word(w);
      end
      @(negedge clk);
      cmd_valid = 0; dma_valid = 0;
      check_all();
   endtask

   task automatic send_d(input logic [31:0] w);
      send(w, 0, 2'd0, 0);
   endtask

   function automatic logic [31:0] rand_payload();
      logic [31:0] v;
      v = $urandom;
      if ($urandom_range(3) == 0) v[31:24] = 8'hE1 + 8'($urandom_range(5));
      return v;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [127:0] snap;
      logic [7:0] op;
      void'($urandom(32'd20240611));
      model_reset();
      e_poly = 0; e_unimpl = 0; e_drop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state zero", dut_state(), 128'(0));
      chk("R1 pulses low", 128'({poly_valid, unimpl_cmd, dma_drop}), 128'(0));
      chk("R1 cmd_ready", 128'(cmd_ready), 128'(1));

      // R3 .. R7 directed settings
      send_d(32'hE1_003FFF);
      send_d(32'hE2_0FFFFF);
      send_d(32'hE3_07FFFF);
      send_d(32'hE4_012345);
      send_d({8'hE5, 2'b00, 11'h400, 11'h7FF}); // R6 both negative
      send_d(32'hE6_000002);

      // R2 low opcodes change nothing
      snap = dut_state();
      send_d(32'h00_FFFFFF);
      send_d(32'h1F_ABCDEF);
      send_d(32'h02_123456);
      chk("R2 low opcodes leave state", dut_state(), snap);

      // R13 longest polygon: textured shaded quad, 12 words
      send_d(32'h3E_000000);
      for (int i = 0; i < 11; i++) send_d(32'hE1_000000 | i);
      chk("R13 12-word packet completed", 128'(poly_words), 128'(12));

      // R9 payload that looks like settings
      snap = dut_state();
      send_d(32'h20_000000);
      send_d(32'hE1_3FFF00);
      send_d(32'hE5_3FFFFF);
      chk("R9 payload ignored mid-packet", dut_state(), snap);
      send_d(32'hE6_000003);
      chk("R9 packet done", 128'(poly_valid), 128'(1));

      // R10 rejected DMA mid-polygon, with a colliding direct word (R12)
      send_d(32'h28_000000);
      send(32'hE2_0FFFFF, 1, 2'd1, 1);
      send(32'hE3_000000, 1, 2'd0, 0);
      send(32'h11_111111, 1, 2'd2, 0);
      for (int i = 0; i < 3; i++) send_d($urandom);

      // R11 undecoded high opcodes
      send_d(32'h40_000000);
      send_d(32'hE0_000000);
      send_d(32'hFF_FFFFFF);

      // random packets
      for (int n = 0; n < 400; n++) begin
         int kind;
         bit via;
         logic [1:0] dir;
         kind = $urandom_range(5);
         case (kind)
            0, 1: op = 8'h20 | 8'($urandom_range(31));
            2:    op = 8'hE1 + 8'($urandom_range(5));
            3:    op = 8'($urandom_range(31));
            default: op = 8'($urandom_range(255));
         endcase
         for (int k = 0; k < pkt_len(op); k++) begin
            logic [31:0] w;
            w = (k == 0) ? {op, 24'($urandom)} : rand_payload();
            via = ($urandom_range(3) == 0);
            dir = 2'($urandom_range(3));
            if (via && dir != 2'd2) begin
               send(rand_payload(), 1, dir, $urandom_range(1) == 1);
            end
            send(w, via, 2'd2, 0);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule